// File: doc/BRIEF.md
# Sequential Stream-Buffer Prefetcher

This block sits beside a cache and supplies blocks that the cache is likely to miss on next. When the cache misses on a block address that the prefetcher is not already tracking, the block restarts its stream: it discards what it holds and begins fetching the blocks that follow the missed one from memory, one at a time. Those blocks go into a small FIFO of its own, not into the cache. A prefetched block therefore never evicts anything the cache holds until the cache actually asks for it.

Every cache miss is also presented to the prefetcher. One cycle later the prefetcher answers with a result. If the miss address equals the oldest block in the FIFO and that block has arrived without error, the answer is a hit and carries the block data, which the cache can use as its refill. When an entry is consumed, a slot is freed and the next sequential block is requested. A purely sequential miss stream is therefore served from the buffer once the stream is warm. Prefetches are advisory. A memory error on a prefetch only leaves that entry unusable, and the cache then fetches the block itself.

Memory requests are issued one block address at a time over a valid/ready port. Responses come back in request order over a valid-only port that carries data and an error flag.

Top module: `sbp_stream_prefetch`

## Requirements
- R1: After reset, res_valid, res_hit and mem_req_valid are all 0. No request is issued until the first miss.
- R2: A miss that does not match the stream head returns res_hit=0 and res_data=0 one cycle later. The buffer then requests blocks A+1, A+2, A+3 and A+4 in that order, where A is the miss address.
- R3: A miss on the stream head whose data has arrived without error returns res_valid=1, res_hit=1 and that block's data on res_data one cycle after miss_valid.
- R4: Consuming the head frees a slot. The next request is then for the block after the newest one requested (A+5 after the first hit in a stream started at A).
- R5: With misses on consecutive block addresses, spaced beyond the memory latency, every miss after the first one hits.
- R6: A non-matching miss flushes the buffer. Blocks of the old stream no longer hit.
- R7: A response with mem_rsp_err=1 leaves its entry invalid. A miss on that block gives res_hit=0, and the stream continues so that the following block hits.
- R8: Responses to requests issued before a flush are discarded and never appear as hit data.
- R9: A miss on a head entry whose response is still outstanding returns res_hit=0 and consumes the entry. Its late response is dropped, and later blocks of the stream are still served with correct data.
- R10: mem_req_valid is 0 in every cycle with miss_valid=1. At most DEPTH live prefetches are held or in flight.
- R11: Block addresses wrap modulo 2^ADDR_W, so the block after all-ones is block 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | Cache miss presented this cycle |
| miss_addr | input | ADDR_W | Block address of the miss |
| res_valid | output | 1 | Result for the miss of the previous cycle |
| res_hit | output | 1 | Block served from the stream buffer |
| res_data | output | DATA_W | Block data on a hit, zero otherwise |
| mem_req_valid | output | 1 | Prefetch request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | ADDR_W | Block address to prefetch |
| mem_rsp_valid | input | 1 | Prefetch response valid |
| mem_rsp_data | input | DATA_W | Response block data |
| mem_rsp_err | input | 1 | Response carries an error |

## Verification
The assertions assume that memory returns exactly one response per accepted request, in request order, and never returns a response with nothing outstanding. The bench memory model follows these rules by construction: it is a fixed-latency shift pipeline that is fed only by accepted requests and is cleared only while reset is held. The bench also keeps the number of requests in flight far below the outstanding-counter limit, by spacing most misses well beyond the memory latency and by using back-to-back misses only in short bursts.

// File: rtl/sbp_pkg.sv
package sbp_pkg;

    // Life cycle of one buffer slot.
    typedef enum logic [1:0] {
        SL_FREE = 2'd0,   // not allocated
        SL_WAIT = 2'd1,   // request sent, response pending
        SL_FULL = 2'd2,   // data present and usable
        SL_VOID = 2'd3    // response had an error; never served
    } slot_st_e;

    // Decision taken on the miss presented this cycle.
    typedef struct packed {
        logic match;      // miss equals the logical stream head
        logic pop;        // an allocated head entry is consumed
        logic skip;       // head not yet allocated; advance request pointer
        logic flush;      // miss outside the stream: restart
        logic hit;        // consumed entry had usable data
        logic late;       // consumed entry still awaits its response
    } miss_act_t;

    function automatic logic st_usable(slot_st_e s);
        return s == SL_FULL;
    endfunction

    function automatic logic st_waiting(slot_st_e s);
        return s == SL_WAIT;
    endfunction

endpackage

// File: rtl/sbp_slot_array.sv
module sbp_slot_array
    import sbp_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              alloc,
    input  logic [ADDR_W-1:0] alloc_addr,
    input  logic              fill,
    input  logic [DATA_W-1:0] fill_data,
    input  logic              fill_err,
    input  logic              pop,
    output logic [ADDR_W-1:0] head_addr,
    output slot_st_e          head_st,
    output logic [DATA_W-1:0] head_data,
    output logic              empty,
    output logic              has_room,
    output logic              fill_found,
    output logic              fill_is_head
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = PTR_W + 1;
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

    slot_st_e          st_q   [DEPTH];
    logic [ADDR_W-1:0] addr_q [DEPTH];
    logic [DATA_W-1:0] data_q [DEPTH];
    logic [PTR_W-1:0]  hd_q, tl_q, fidx;
    logic [CNT_W-1:0]  cnt_q;

    // Oldest waiting slot, searched from the head in allocation order.
    always_comb begin
        logic [PTR_W-1:0] idx;
        fidx       = '0;
        fill_found = 1'b0;
        idx        = '0;
        for (int k = 0; k < DEPTH; k++) begin
            idx = hd_q + PTR_W'(k);
            if (!fill_found && (CNT_W'(k) < cnt_q) && st_waiting(st_q[idx])) begin
                fill_found = 1'b1;
                fidx       = idx;
            end
        end
    end

    assign fill_is_head = fill_found && (fidx == hd_q);
    assign head_addr    = addr_q[hd_q];
    assign head_st      = st_q[hd_q];
    assign head_data    = data_q[hd_q];
    assign empty        = (cnt_q == '0);
    assign has_room     = (cnt_q != CNT_MAX);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            for (int k = 0; k < DEPTH; k++) st_q[k] <= SL_FREE;
            hd_q  <= '0;
            tl_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (fill && fill_found) begin
                st_q[fidx] <= fill_err ? SL_VOID : SL_FULL;
                if (!fill_err) data_q[fidx] <= fill_data;
            end
            if (pop) begin
                st_q[hd_q] <= SL_FREE;
                hd_q       <= hd_q + PTR_W'(1);
            end
            if (alloc) begin
                st_q[tl_q]   <= SL_WAIT;
                addr_q[tl_q] <= alloc_addr;
                tl_q         <= tl_q + PTR_W'(1);
            end
            cnt_q <= cnt_q + CNT_W'(alloc) - CNT_W'(pop);
        end
    end

    a_r10_count_bound: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_MAX);
    a_r10_no_alloc_when_full: assert property (@(posedge clk) disable iff (rst)
        alloc |-> has_room);
    a_r9_no_pop_when_empty: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);

endmodule

// File: rtl/sbp_issue.sv
module sbp_issue #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic [ADDR_W-1:0] restart_addr,
    input  logic              skip,
    input  logic              slot_room,
    input  logic              miss_busy,
    input  logic              mem_req_ready,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic              fire,
    output logic              active,
    output logic [ADDR_W-1:0] next_addr
);
    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    logic              act_q;
    logic [ADDR_W-1:0] nxt_q;

    // Requests stand aside while a miss is being decided.
    assign mem_req_valid = act_q && slot_room && !miss_busy;
    assign mem_req_addr  = nxt_q;
    assign fire          = mem_req_valid && mem_req_ready;
    assign active        = act_q;
    assign next_addr     = nxt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= 1'b0;
            nxt_q <= '0;
        end else if (restart) begin
            act_q <= 1'b1;
            nxt_q <= restart_addr + ONE;
        end else if (skip || fire) begin
            nxt_q <= nxt_q + ONE;
        end
    end

    a_r1_idle_until_miss: assert property (@(posedge clk) disable iff (rst)
        !act_q |-> !mem_req_valid);
    a_r2_addr_held_while_stalled: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready && !miss_busy) |=>
            (restart || skip || ($past(mem_req_addr) == mem_req_addr)) || !mem_req_valid);

endmodule

// File: rtl/sbp_rsp_track.sv
module sbp_rsp_track #(
    parameter int CNT_W = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    input  logic rsp_valid,
    input  logic flush,
    input  logic late_pop,
    output logic rsp_live
);
    logic [CNT_W-1:0] out_q, disc_q, out_nx;

    assign rsp_live = rsp_valid && (disc_q == '0);
    assign out_nx   = out_q + CNT_W'(fire) - CNT_W'(rsp_valid);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q  <= '0;
            disc_q <= '0;
        end else begin
            out_q <= out_nx;
            if (flush)
                disc_q <= out_nx;
            else
                disc_q <= disc_q - CNT_W'(rsp_valid && !rsp_live) + CNT_W'(late_pop);
        end
    end

    a_r8_rsp_only_when_outstanding: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (out_q != '0));
    a_r8_discard_within_outstanding: assert property (@(posedge clk) disable iff (rst)
        disc_q <= out_q);
    a_r10_no_counter_wrap: assert property (@(posedge clk) disable iff (rst)
        fire |-> (out_q != '1));

endmodule

// File: rtl/sbp_stream_prefetch.sv
module sbp_stream_prefetch
    import sbp_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64,
    parameter int DEPTH  = 4,
    parameter int CNT_W  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              miss_valid,
    input  logic [ADDR_W-1:0] miss_addr,
    output logic              res_valid,
    output logic              res_hit,
    output logic [DATA_W-1:0] res_data,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data,
    input  logic              mem_rsp_err
);
    logic [ADDR_W-1:0] head_addr, next_addr;
    slot_st_e          head_st;
    logic [DATA_W-1:0] head_data;
    logic              empty, has_room, fill_found, fill_is_head;
    logic              fire, active, rsp_live;
    miss_act_t         act;

    // Decide what the presented miss does to the stream.
    always_comb begin
        act       = '0;
        act.match = miss_valid && active &&
                    (empty ? (next_addr == miss_addr) : (head_addr == miss_addr));
        act.pop   = act.match && !empty;
        act.skip  = act.match && empty;
        act.flush = miss_valid && !act.match;
        act.hit   = act.pop && st_usable(head_st);
        act.late  = act.pop && st_waiting(head_st) && !(rsp_live && fill_is_head);
    end

    sbp_slot_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_slots (
        .clk          (clk),
        .rst          (rst),
        .clear        (act.flush),
        .alloc        (fire),
        .alloc_addr   (mem_req_addr),
        .fill         (rsp_live),
        .fill_data    (mem_rsp_data),
        .fill_err     (mem_rsp_err),
        .pop          (act.pop),
        .head_addr    (head_addr),
        .head_st      (head_st),
        .head_data    (head_data),
        .empty        (empty),
        .has_room     (has_room),
        .fill_found   (fill_found),
        .fill_is_head (fill_is_head)
    );

    sbp_issue #(.ADDR_W(ADDR_W)) u_issue (
        .clk           (clk),
        .rst           (rst),
        .restart       (act.flush),
        .restart_addr  (miss_addr),
        .skip          (act.skip),
        .slot_room     (has_room),
        .miss_busy     (miss_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_valid (mem_req_valid),
        .mem_req_addr  (mem_req_addr),
        .fire          (fire),
        .active        (active),
        .next_addr     (next_addr)
    );

    sbp_rsp_track #(.CNT_W(CNT_W)) u_track (
        .clk       (clk),
        .rst       (rst),
        .fire      (fire),
        .rsp_valid (mem_rsp_valid),
        .flush     (act.flush),
        .late_pop  (act.late),
        .rsp_live  (rsp_live)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_hit   <= 1'b0;
            res_data  <= '0;
        end else begin
            res_valid <= miss_valid;
            res_hit   <= act.hit;
            res_data  <= act.hit ? head_data : '0;
        end
    end

    a_r10_no_req_in_miss_cycle: assert property (@(posedge clk) disable iff (rst)
        miss_valid |-> !mem_req_valid);
    a_r3_result_follows_miss: assert property (@(posedge clk) disable iff (rst)
        miss_valid |=> res_valid);
    a_r3_hit_implies_result: assert property (@(posedge clk) disable iff (rst)
        res_hit |-> res_valid);
    a_r8_live_rsp_has_slot: assert property (@(posedge clk) disable iff (rst)
        rsp_live |-> fill_found);
    a_r2_miss_data_zero: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_hit) |-> (res_data == '0));

endmodule

// File: tb/sim_sbp_stream_prefetch.sv
module sim_sbp_stream_prefetch;
    localparam int AW  = 32;
    localparam int DW  = 64;
    localparam int LAT = 4;
    localparam int GAP = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          miss_valid = 1'b0;
    logic [AW-1:0] miss_addr = '0;
    logic          res_valid, res_hit;
    logic [DW-1:0] res_data;
    logic          mem_req_valid, mem_req_ready;
    logic [AW-1:0] mem_req_addr;
    logic          mem_rsp_valid, mem_rsp_err;
    logic [DW-1:0] mem_rsp_data;

    int errors = 0;
    int total  = 0;

    always #2 clk = ~clk;   // 4 ns period

    sbp_stream_prefetch #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(4), .CNT_W(6)) u0 (
        .clk(clk), .rst(rst), .miss_valid(miss_valid), .miss_addr(miss_addr),
        .res_valid(res_valid), .res_hit(res_hit), .res_data(res_data),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err)
    );

    // Memory model: fixed latency, in order, error on low nibble 4'hD.
    logic          pv [LAT];
    logic [AW-1:0] pa [LAT];
    logic [AW-1:0] req_log [256];
    int            nlog = 0;

    assign mem_req_ready = 1'b1;
    assign mem_rsp_valid = pv[LAT-1];
    assign mem_rsp_data  = {~pa[LAT-1], pa[LAT-1]};
    assign mem_rsp_err   = (pa[LAT-1][3:0] == 4'hD);

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < LAT; i++) begin pv[i] <= 1'b0; pa[i] <= '0; end
        end else begin
            pv[0] <= mem_req_valid && mem_req_ready;
            pa[0] <= mem_req_addr;
            for (int i = 1; i < LAT; i++) begin pv[i] <= pv[i-1]; pa[i] <= pa[i-1]; end
            if (mem_req_valid && mem_req_ready && nlog < 256) begin
                req_log[nlog] <= mem_req_addr;
                nlog <= nlog + 1;
            end
        end
    end

    function automatic logic [DW-1:0] blk(logic [AW-1:0] a);
        return {~a, a};
    endfunction

    task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Present one miss, then check the registered result.
    task automatic do_miss(string req, logic [AW-1:0] a, logic exp_hit);
        @(negedge clk);
        miss_valid = 1'b1;
        miss_addr  = a;
        @(negedge clk);
        miss_valid = 1'b0;
        chk({req, " res_valid"}, DW'(res_valid), DW'(1));
        chk({req, " res_hit"}, DW'(res_hit), DW'(exp_hit));
        chk({req, " res_data"}, res_data, exp_hit ? blk(a) : '0);
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    // {miss address, expected hit}, each miss spaced beyond the latency.
    localparam logic [AW:0] VEC [16] = '{
        {32'h100, 1'b0}, {32'h101, 1'b1}, {32'h102, 1'b1}, {32'h103, 1'b1},
        {32'h104, 1'b1}, {32'h105, 1'b1}, {32'h106, 1'b1}, {32'h200, 1'b0},
        {32'h103, 1'b0}, {32'h104, 1'b1}, {32'h10C, 1'b0}, {32'h10D, 1'b0},
        {32'h10E, 1'b1}, {32'h10F, 1'b1}, {32'h110, 1'b1}, {32'h111, 1'b1}
    };

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, total);
        $finish;
    end

    initial begin
        int base;
        repeat (3) @(negedge clk);
        // R1: reset state and no request before the first miss
        chk("R1 res_valid", DW'(res_valid), DW'(0));
        chk("R1 res_hit", DW'(res_hit), DW'(0));
        rst = 1'b0;
        idle(5);
        chk("R1 no request while idle", DW'(mem_req_valid), DW'(0));
        chk("R1 no request logged", DW'(nlog), DW'(0));

        // R2 R3 R5 R6 R7: table walk (R5 via 0x101..0x106, R6 via 0x103 after 0x200, R7 via 0x10D)
        for (int v = 0; v < 16; v++) begin
            do_miss("R2/R3/R5/R6/R7 table", VEC[v][AW:1], VEC[v][0]);
            idle(GAP);
        end

        // R2: request order after a restart; R4: one new request after a hit
        base = nlog;
        do_miss("R2 restart", 32'h300, 1'b0);
        idle(GAP);
        chk("R2 request count", DW'(nlog - base), DW'(4));
        for (int k = 0; k < 4; k++)
            chk("R2 request order", DW'(req_log[base + k]), DW'(32'h301 + k));
        do_miss("R4 hit", 32'h301, 1'b1);
        idle(GAP);
        chk("R4 refill count", DW'(nlog - base), DW'(5));
        chk("R4 refill address", DW'(req_log[base + 4]), DW'(32'h305));

        // R8: flush while prefetches of the old stream are in flight
        do_miss("R8 first stream", 32'h400, 1'b0);
        do_miss("R8 flush in flight", 32'h500, 1'b0);
        idle(GAP);
        do_miss("R8 new stream data", 32'h501, 1'b1);
        do_miss("R8 next block", 32'h502, 1'b1);
        idle(GAP);

        // R9: misses on heads whose responses are still pending
        do_miss("R9 restart", 32'h600, 1'b0);
        do_miss("R9 pending head", 32'h601, 1'b0);
        do_miss("R9 pending head", 32'h602, 1'b0);
        idle(GAP + 8);
        do_miss("R9 stream intact", 32'h603, 1'b1);
        idle(GAP);
        do_miss("R9 stream intact", 32'h604, 1'b1);
        idle(GAP);

        // R11: wrap past the top of the address space
        do_miss("R11 restart at top", 32'hFFFF_FFFF, 1'b0);
        idle(GAP);
        do_miss("R11 wrapped block", 32'h0, 1'b1);

        // R10: no request in a cycle with a miss presented
        @(negedge clk);
        miss_valid = 1'b1;
        miss_addr  = 32'h1;
        #0;
        chk("R10 request held off during miss", DW'(mem_req_valid), DW'(0));
        @(negedge clk);
        miss_valid = 1'b0;
        chk("R10 hit while refilling", DW'(res_hit), DW'(1));

        $display("Result: errors=%0d of %0d checks", errors, total);
        $finish;
    end

endmodule